// File: doc/BRIEF.md
# Downstream Preamble Gate for a Hub Repeater

This block controls the downstream direction of a repeater with one upstream port and four downstream ports. It watches the decoded line state and the PID strobe from the upstream receiver and, for each packet, chooses which downstream ports carry the traffic. Ports flagged as low-speed stay silent for ordinary full-speed packets. They are opened only for the low-speed data that follows a preamble PID. Their slow drivers turn on a fixed number of full-speed bit times after the preamble and turn off when the end-of-packet completes.

A four-state machine holds the packet context. The states are `ST_IDLE` (bus idle), `ST_FSPKT` (full-speed packet in progress), `ST_PREGAP` (preamble seen, counting the gap before low-speed data) and `ST_LSPKT` (low-speed data being repeated). The transitions are:

- `ST_IDLE`→`ST_FSPKT` on a K state.
- `ST_FSPKT`→`ST_PREGAP` on a preamble PID strobe.
- `ST_PREGAP`→`ST_LSPKT` when the gap counter expires.
- Any busy state→`ST_IDLE` on end-of-packet. End-of-packet has priority over every other transition.

Traffic arriving from downstream ports is merged onto the upstream transmitter, which always uses full-speed drivers. This merge runs only while the downstream direction is idle. Speed classification is done outside the block: at connect, a pulled-up D+ marks a full-speed port and a pulled-up D- marks a low-speed port. The result arrives here as a per-port flag.

Top module: `hubgate_ds_ctrl`

## Requirements
- R1: While reset is held, and after reset with no downstream activity, `fwd_en`, `ls_drv_en` and `up_tx_en` are all zero. The state returns to idle.
- R2: The line code is 2'b00 SE0, 2'b01 J, 2'b10 K, 2'b11 SE1. A K seen in idle starts a packet. From the cycle after that edge, `fwd_en` equals `port_en & ~port_ls`. SE1 or J in idle starts nothing.
- R3: A low-speed port receives no forwarding during a packet without a preamble. A PID strobe with any value other than 8'h3C leaves the packet full-speed only.
- R4: A PID strobe with value 8'h3C during a full-speed packet starts the gap. After `GAP_BITS` further `bit_stb` pulses (default 2, at most 4), from the next cycle `fwd_en = port_en` and `ls_drv_en = port_en & port_ls`. `ls_drv_en` is never set on a full-speed port.
- R5: End-of-packet is recognised when SE0 is present in a cycle with `bit_stb` and J follows. From the cycle after that J, all forward and low-speed enables are zero. SE0 without a `bit_stb` pulse, followed by J, does not end the packet.
- R6: A port with `port_en` low never has `fwd_en` or `ls_drv_en` high. A change of `port_en` acts in the same cycle.
- R7: `up_tx_en` is the OR of `dn_act & port_en` while idle. It is zero while a downstream packet is being repeated.
- R8: A preamble PID strobe in idle, or during low-speed data, has no effect on the outputs.
- R9: End-of-packet during the preamble gap returns to idle without ever raising `ls_drv_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_stb | input | 1 | One-cycle pulse per full-speed bit time |
| up_line | input | 2 | Decoded upstream line state (R2 encoding) |
| pid_vld | input | 1 | Strobe: `pid_val` holds a received PID byte |
| pid_val | input | 8 | PID byte from the upstream receiver |
| port_en | input | NUM_PORTS | Per-port enabled and connected flag |
| port_ls | input | NUM_PORTS | Per-port low-speed flag |
| dn_act | input | NUM_PORTS | Per-port activity heading upstream |
| fwd_en | output | NUM_PORTS | Per-port downstream forward enable |
| ls_drv_en | output | NUM_PORTS | Per-port low-speed driver enable |
| up_tx_en | output | 1 | Upstream full-speed transmit enable |

## Verification
The forward and low-speed enables are decoded from the registered state, so each one moves one clock after the edge that samples its stimulus. This applies to the K that opens a packet, the last gap strobe and the J that closes end-of-packet. `port_en` and `dn_act` act combinationally within the same cycle. The bench drives each vector on the falling edge and compares 1 ns after the next rising edge, so every expected value covers exactly one register stage. The rows around the gap confirm that the low-speed enables stay low until the strobe that completes `GAP_BITS`. Reset is checked 1 ns after it is asserted, because it is asynchronous.

// File: rtl/hubgate_pkg.sv
package hubgate_pkg;
    typedef enum logic [1:0] {
        LN_SE0 = 2'b00,
        LN_J   = 2'b01,
        LN_K   = 2'b10,
        LN_SE1 = 2'b11
    } hg_line_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FSPKT,
        ST_PREGAP,
        ST_LSPKT
    } hg_state_e;

    localparam logic [7:0] PID_PRE = 8'h3C;
endpackage

// File: rtl/hubgate_eop_det.sv
module hubgate_eop_det
    import hubgate_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] line,
    input  logic       bit_stb,
    output logic       eop
);
    logic se0_held;

    // SE0 counts only once a full bit time has elapsed inside it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            se0_held <= 1'b0;
        else if (line == LN_SE0 && bit_stb)
            se0_held <= 1'b1;
        else if (line != LN_SE0)
            se0_held <= 1'b0;
    end

    assign eop = se0_held && (line == LN_J);
endmodule

// File: rtl/hubgate_gap_cnt.sv
module hubgate_gap_cnt #(
    parameter int GAP_BITS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic bit_stb,
    output logic done
);
    localparam int CW = $clog2(GAP_BITS + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run)
            cnt <= '0;
        else if (bit_stb && !done)
            cnt <= cnt + 1'b1;
    end

    assign done = run && bit_stb && (cnt == CW'(GAP_BITS - 1));
endmodule

// File: rtl/hubgate_port_mux.sv
module hubgate_port_mux #(
    parameter int NUM_PORTS = 4
) (
    input  logic                 fs_win,
    input  logic                 ls_win,
    input  logic                 up_ok,
    input  logic [NUM_PORTS-1:0] port_en,
    input  logic [NUM_PORTS-1:0] port_ls,
    input  logic [NUM_PORTS-1:0] dn_act,
    output logic [NUM_PORTS-1:0] fwd_en,
    output logic [NUM_PORTS-1:0] ls_drv_en,
    output logic                 up_tx_en
);
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign fwd_en[p]    = port_en[p] & (ls_win | (fs_win & ~port_ls[p]));
        assign ls_drv_en[p] = port_en[p] & port_ls[p] & ls_win;
    end

    assign up_tx_en = up_ok & (|(dn_act & port_en));
endmodule

// File: rtl/hubgate_ds_ctrl.sv
module hubgate_ds_ctrl
    import hubgate_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int GAP_BITS  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_stb,
    input  logic [1:0]           up_line,
    input  logic                 pid_vld,
    input  logic [7:0]           pid_val,
    input  logic [NUM_PORTS-1:0] port_en,
    input  logic [NUM_PORTS-1:0] port_ls,
    input  logic [NUM_PORTS-1:0] dn_act,
    output logic [NUM_PORTS-1:0] fwd_en,
    output logic [NUM_PORTS-1:0] ls_drv_en,
    output logic                 up_tx_en
);
    hg_state_e st, st_nxt;
    logic      eop_w;
    logic      gap_done;
    logic      pre_hit;
    logic      fs_win, ls_win, gap_run, up_ok;

    assign pre_hit = pid_vld && (pid_val == PID_PRE);

    hubgate_eop_det i_eop (
        .clk     (clk),
        .rst_n   (rst_n),
        .line    (up_line),
        .bit_stb (bit_stb),
        .eop     (eop_w)
    );

    hubgate_gap_cnt #(.GAP_BITS(GAP_BITS)) i_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (gap_run),
        .bit_stb (bit_stb),
        .done    (gap_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st <= ST_IDLE;
        else
            st <= st_nxt;
    end

    // transitions; end-of-packet wins over everything else
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE: begin
                if (up_line == LN_K)
                    st_nxt = ST_FSPKT;
            end
            ST_FSPKT: begin
                if (eop_w)
                    st_nxt = ST_IDLE;
                else if (pre_hit)
                    st_nxt = ST_PREGAP;
            end
            ST_PREGAP: begin
                if (eop_w)
                    st_nxt = ST_IDLE;
                else if (gap_done)
                    st_nxt = ST_LSPKT;
            end
            ST_LSPKT: begin
                if (eop_w)
                    st_nxt = ST_IDLE;
            end
        endcase
    end

    // output decode
    always_comb begin
        fs_win  = 1'b0;
        ls_win  = 1'b0;
        gap_run = 1'b0;
        up_ok   = 1'b0;
        unique case (st)
            ST_IDLE:   up_ok = 1'b1;
            ST_FSPKT:  fs_win = 1'b1;
            ST_PREGAP: begin
                fs_win  = 1'b1;
                gap_run = 1'b1;
            end
            ST_LSPKT: begin
                fs_win = 1'b1;
                ls_win = 1'b1;
            end
        endcase
    end

    hubgate_port_mux #(.NUM_PORTS(NUM_PORTS)) i_mux (
        .fs_win    (fs_win),
        .ls_win    (ls_win),
        .up_ok     (up_ok),
        .port_en   (port_en),
        .port_ls   (port_ls),
        .dn_act    (dn_act),
        .fwd_en    (fwd_en),
        .ls_drv_en (ls_drv_en),
        .up_tx_en  (up_tx_en)
    );
endmodule

// File: rtl/hubgate_chk.sv
module hubgate_chk
    import hubgate_pkg::*;
#(
    parameter int NUM_PORTS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bit_stb,
    input logic                 pid_vld,
    input logic [7:0]           pid_val,
    input logic [NUM_PORTS-1:0] port_en,
    input logic [NUM_PORTS-1:0] port_ls,
    input logic [NUM_PORTS-1:0] fwd_en,
    input logic [NUM_PORTS-1:0] ls_drv_en,
    input logic                 up_tx_en,
    input hg_state_e            st,
    input logic                 eop
);
    logic       pend;
    logic [3:0] bits;
    logic       pre_seen;

    // budget watch: strobes counted from preamble acceptance to driver enable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= 1'b0;
            bits <= '0;
        end else if (st == ST_FSPKT && pid_vld && pid_val == PID_PRE && !eop) begin
            pend <= 1'b1;
            bits <= '0;
        end else if ((|ls_drv_en) || eop) begin
            pend <= 1'b0;
        end else if (pend && bit_stb && bits != 4'hF) begin
            bits <= bits + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pre_seen <= 1'b0;
        else if (eop)
            pre_seen <= 1'b0;
        else if (st == ST_FSPKT && pid_vld && pid_val == PID_PRE)
            pre_seen <= 1'b1;
    end

    AST_FWD_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((fwd_en | ls_drv_en) & ~port_en) == '0); // R6
    AST_LS_ON_LS_PORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_drv_en & ~(port_ls & fwd_en)) == '0); // R4
    AST_LS_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> (bits <= 4'd4)); // R4
    AST_LS_OFF_AT_EOP: assert property (@(posedge clk) disable iff (!rst_n)
        eop |=> (ls_drv_en == '0 && fwd_en == '0)); // R5
    AST_UP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_en != '0) |-> !up_tx_en); // R7
    AST_LS_AFTER_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|ls_drv_en) |-> pre_seen); // R3
endmodule

bind hubgate_ds_ctrl hubgate_chk #(.NUM_PORTS(NUM_PORTS)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_stb   (bit_stb),
    .pid_vld   (pid_vld),
    .pid_val   (pid_val),
    .port_en   (port_en),
    .port_ls   (port_ls),
    .fwd_en    (fwd_en),
    .ls_drv_en (ls_drv_en),
    .up_tx_en  (up_tx_en),
    .st        (st),
    .eop       (eop_w)
);

// File: tb/test_hubgate_ds_ctrl.sv
`timescale 1ns/1ps
module test_hubgate_ds_ctrl;
    localparam int NP = 4;
    localparam int NV = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bit_stb = 1'b0;
    logic [1:0]    up_line = 2'b01;
    logic          pid_vld = 1'b0;
    logic [7:0]    pid_val = 8'h00;
    logic [NP-1:0] port_en = '0;
    logic [NP-1:0] port_ls = '0;
    logic [NP-1:0] dn_act = '0;
    logic [NP-1:0] fwd_en, ls_drv_en;
    logic          up_tx_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    hubgate_ds_ctrl #(.NUM_PORTS(NP), .GAP_BITS(2)) i_hubgate_ds_ctrl (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .up_line(up_line),
        .pid_vld(pid_vld), .pid_val(pid_val), .port_en(port_en),
        .port_ls(port_ls), .dn_act(dn_act), .fwd_en(fwd_en),
        .ls_drv_en(ls_drv_en), .up_tx_en(up_tx_en)
    );

    // row: {req, line, stb, pidv, pid, en, ls, dn, exp_fwd, exp_ls, exp_up}
    function automatic logic [36:0] v(input logic [3:0] rq, input logic [1:0] ln,
        input logic s, input logic pv, input logic [7:0] pid, input logic [3:0] en,
        input logic [3:0] ls, input logic [3:0] dn, input logic [3:0] f,
        input logic [3:0] l, input logic u);
        return {rq, ln, s, pv, pid, en, ls, dn, f, l, u};
    endfunction

    // line: 0 SE0, 1 J, 2 K, 3 SE1; ports 0 and 2 low-speed
    localparam logic [36:0] VEC [NV] = '{
        v(1, 1,0,0,8'h00, 4'hF,4'h5,4'h0, 4'h0,4'h0,1'b0), // R1 idle
        v(7, 1,0,0,8'h00, 4'hF,4'h5,4'h2, 4'h0,4'h0,1'b1), // R7 merge while idle
        v(2, 2,0,0,8'h00, 4'hF,4'h5,4'h0, 4'hA,4'h0,1'b0), // R2 K opens packet
        v(2, 1,1,0,8'h00, 4'hF,4'h5,4'h0, 4'hA,4'h0,1'b0), // R2
        v(3, 2,1,1,8'hC3, 4'hF,4'h5,4'h0, 4'hA,4'h0,1'b0), // R3 other PID
        v(5, 0,0,0,8'h00, 4'hF,4'h5,4'h0, 4'hA,4'h0,1'b0), // R5 short SE0
        v(5, 1,0,0,8'h00, 4'hF,4'h5,4'h0, 4'hA,4'h0,1'b0), // R5 no end
        v(5, 0,1,0,8'h00, 4'hF,4'h5,4'h0, 4'hA,4'h0,1'b0), // R5 full SE0
        v(5, 1,0,0,8'h00, 4'hF,4'h5,4'h0, 4'h0,4'h0,1'b0), // R5 end
        v(8, 1,0,1,8'h3C, 4'hF,4'h5,4'h0, 4'h0,4'h0,1'b0), // R8 preamble in idle
        v(2, 2,0,0,8'h00, 4'hF,4'h5,4'h0, 4'hA,4'h0,1'b0), // R2
        v(4, 1,1,1,8'h3C, 4'hF,4'h5,4'h0, 4'hA,4'h0,1'b0), // R4 preamble
        v(4, 1,1,0,8'h00, 4'hF,4'h5,4'h0, 4'hA,4'h0,1'b0), // R4 gap bit 1
        v(4, 1,1,0,8'h00, 4'hF,4'h5,4'h0, 4'hF,4'h5,1'b0), // R4 gap bit 2
        v(7, 2,1,0,8'h00, 4'hF,4'h5,4'hF, 4'hF,4'h5,1'b0), // R7 quiet upstream
        v(8, 2,1,1,8'h3C, 4'hF,4'h5,4'h0, 4'hF,4'h5,1'b0), // R8 preamble in LS data
        v(5, 0,1,0,8'h00, 4'hF,4'h5,4'h0, 4'hF,4'h5,1'b0), // R5
        v(5, 1,0,0,8'h00, 4'hF,4'h5,4'h0, 4'h0,4'h0,1'b0), // R5 drivers off
        v(2, 2,0,0,8'h00, 4'hF,4'h5,4'h0, 4'hA,4'h0,1'b0), // R2
        v(4, 1,1,1,8'h3C, 4'hF,4'h5,4'h0, 4'hA,4'h0,1'b0), // R4
        v(9, 0,1,0,8'h00, 4'hF,4'h5,4'h0, 4'hA,4'h0,1'b0), // R9 SE0 in gap
        v(9, 1,0,0,8'h00, 4'hF,4'h5,4'h0, 4'h0,4'h0,1'b0), // R9 abort
        v(9, 1,1,0,8'h00, 4'hF,4'h5,4'h0, 4'h0,4'h0,1'b0), // R9 stays idle
        v(6, 2,0,0,8'h00, 4'h6,4'h5,4'h0, 4'h2,4'h0,1'b0), // R6 partial enable
        v(4, 1,1,1,8'h3C, 4'h6,4'h5,4'h0, 4'h2,4'h0,1'b0), // R4
        v(4, 1,1,0,8'h00, 4'h6,4'h5,4'h0, 4'h2,4'h0,1'b0), // R4
        v(4, 1,1,0,8'h00, 4'h6,4'h5,4'h0, 4'h6,4'h4,1'b0), // R4
        v(6, 1,0,0,8'h00, 4'h0,4'h5,4'h0, 4'h0,4'h0,1'b0), // R6 all disabled
        v(6, 0,1,0,8'h00, 4'h6,4'h5,4'h0, 4'h6,4'h4,1'b0), // R6 re-enabled
        v(5, 1,0,0,8'h00, 4'h6,4'h5,4'h0, 4'h0,4'h0,1'b0), // R5
        v(2, 3,0,0,8'h00, 4'hF,4'h5,4'h0, 4'h0,4'h0,1'b0), // R2 SE1 no start
        v(2, 1,0,0,8'h00, 4'hF,4'h5,4'h0, 4'h0,4'h0,1'b0)  // R2
    };

    task automatic check(input int rq, input logic [3:0] ef, input logic [3:0] el, input logic eu);
        n_chk++;
        if (fwd_en !== ef || ls_drv_en !== el || up_tx_en !== eu) begin
            n_bad++;
            $display("FAIL R%0d: fwd=%h ls=%h up=%b expected fwd=%h ls=%h up=%b",
                     rq, fwd_en, ls_drv_en, up_tx_en, ef, el, eu);
        end
    endtask

    task automatic apply(input logic [36:0] r);
        @(negedge clk);
        up_line = r[32:31]; bit_stb = r[30]; pid_vld = r[29]; pid_val = r[28:21];
        port_en = r[20:17]; port_ls = r[16:13]; dn_act = r[12:9];
        @(posedge clk);
        #1;
        check(int'(r[36:33]), r[8:5], r[4:1], r[0]);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        port_en = 4'hF; port_ls = 4'h5;
        repeat (3) @(posedge clk);
        #1;
        check(1, 4'h0, 4'h0, 1'b0); // R1 during reset
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) apply(VEC[i]);

        // R1: asynchronous reset in the middle of low-speed data
        apply(v(2, 2,0,0,8'h00, 4'hF,4'h5,4'h0, 4'hA,4'h0,1'b0));
        apply(v(4, 1,1,1,8'h3C, 4'hF,4'h5,4'h0, 4'hA,4'h0,1'b0));
        apply(v(4, 1,1,0,8'h00, 4'hF,4'h5,4'h0, 4'hA,4'h0,1'b0));
        apply(v(4, 1,1,0,8'h00, 4'hF,4'h5,4'h0, 4'hF,4'h5,1'b0));
        @(negedge clk);
        bit_stb = 1'b0;
        rst_n = 1'b0;
        #1;
        check(1, 4'h0, 4'h0, 1'b0); // R1 reset clears enables
        @(negedge clk);
        rst_n = 1'b1;
        apply(v(1, 1,0,0,8'h00, 4'hF,4'h5,4'h0, 4'h0,4'h0,1'b0)); // R1 idle after reset
        done = 1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            finish_run();
        end
    end
endmodule